// File: doc/BRIEF.md
# Pseudo-DMA Byte/Halfword Data Port

This block lets a host processor move SCSI data or command bytes itself, one 8-bit or 16-bit access at a time, in place of a bus-mastering DMA engine. It owns two byte FIFOs and a transfer counter. A host write stores bytes into the command FIFO while the controller is collecting a command, and into the data FIFO otherwise. Each stored byte consumes one unit of the transfer count. A host read takes bytes from the same selected FIFO. After an access the port sends a one-cycle check event to the controller sequencer, and it flags when a collected command is ready to run.

The target side fills the data FIFO through a fill stream and empties it through a drain stream. The sequencer takes command bytes through a command output stream. All three streams are valid/ready. On a data-in transfer the sequencer can ask the port to pad the data FIFO with zero bytes up to its full depth. Host accesses use a valid/ready request channel. A halfword access is split into two byte operations, so `acc_ready` is low for exactly one cycle after a halfword is accepted. Read results come back on `rd_valid`/`rd_data` with no back-pressure. The host side holds no buffering, so `fill_ready`, `drain_valid` and `cmd_out_valid` go low in any cycle where a host byte operation uses the same FIFO.

Top module: `pdma_port`

## Requirements
- R1: Size code 0 is one byte, taken from `acc_wdata[7:0]`. Size code 1 is a halfword, stored as `acc_wdata[15:8]` first and `acc_wdata[7:0]` second. In the cycle after a halfword is accepted `acc_ready` is 0, and it is 1 in every other cycle.
- R2: A byte read returns the removed byte in `rd_data[7:0]` with `rd_data[15:8]` zero. A halfword read returns the first removed byte in `rd_data[15:8]` and the second in `rd_data[7:0]`. `rd_valid` is high for one cycle, in the cycle after the last byte operation of the read.
- R3: A host-written byte lowers `xfer_count` by one when the count is nonzero, even if the FIFO is full. When the count is zero the byte is discarded and the count stays the same.
- R4: While `cmd_mode` is 1, host reads and writes use the command FIFO. While it is 0 they use the data FIFO.
- R5: A byte pushed into a full FIFO is dropped. A pop from an empty FIFO returns 0x00. Both FIFOs keep first-in first-out order.
- R6: `chk_evt` is a one-cycle pulse in the cycle after every byte or halfword write. After a read it pulses only if the data FIFO then holds fewer than 2 bytes.
- R7: A `pad_req` pulse with `xfer_count` at most DATA_DEPTH and greater than the data FIFO occupancy fills the data FIFO with 0x00 bytes until it holds DATA_DEPTH bytes. In any other case `pad_req` has no effect.
- R8: `cmd_go` pulses together with the `chk_evt` of a write made with `cmd_mode` at 1 when, after that write, the count is zero and the command FIFO is not empty.
- R9: `drq` is set by `xfer_start` and stays high while the count is nonzero. It falls when the count reaches zero or when `xfer_done` is pulsed.
- R10: Size codes 2 and 3 are accepted but have no effect: no FIFO or count change, no `chk_evt` and no `rd_valid`.
- R11: `fill_ready` is high only while the data FIFO is not full, no pad is in progress and no host byte operation uses the data FIFO. `drain_valid` is high while the data FIFO is not empty and no host byte operation uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_mode | input | 1 | 1 routes host accesses to the command FIFO |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Access accepted when high with acc_valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 ignored |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read result valid, one cycle |
| rd_data | output | 16 | Read result |
| chk_evt | output | 1 | Completion-check event to the sequencer |
| cmd_go | output | 1 | Collected command is ready for execution |
| tc_load | input | 1 | Load the transfer count |
| tc_load_val | input | TC_W | Value for tc_load |
| xfer_start | input | 1 | Arm the data request |
| xfer_done | input | 1 | Complete the transfer, drop drq |
| xfer_count | output | TC_W | Current transfer count |
| drq | output | 1 | Data request to the host |
| pad_req | input | 1 | Request zero padding of the data FIFO |
| fill_valid | input | 1 | Target byte offered to the data FIFO |
| fill_ready | output | 1 | Data FIFO accepts a target byte |
| fill_data | input | 8 | Target byte |
| drain_valid | output | 1 | Data FIFO byte available to the target |
| drain_ready | input | 1 | Target takes the byte |
| drain_data | output | 8 | Head byte of the data FIFO |
| cmd_out_valid | output | 1 | Command byte available |
| cmd_out_ready | input | 1 | Sequencer takes the command byte |
| cmd_out_data | output | 8 | Head byte of the command FIFO |

## Verification
A wrong FIFO pointer or occupancy shows up at the next read as a wrong or zero byte, and one access later as a `chk_evt` that is missing or extra. A lost halfword phase shows up in the same access as `acc_ready` not falling, or as swapped bytes in `rd_data`. A counter fault shows up on `xfer_count` in the cycle right after the write, and later as a `cmd_go` or `drq` level that is wrong. The bench keeps byte-level queues for both FIFOs and the count, so every access is compared at the first cycle where it can be seen.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WIDE = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic logic size_is_legal(input logic [1:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF);
  endfunction
endpackage

// File: rtl/pdma_byte_fifo.sv
`timescale 1ns/1ps
module pdma_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       pop_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_eff, pop_eff;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign push_eff  = push && !full;
  assign pop_eff   = pop && !empty;
  assign pop_data  = empty ? 8'h00 : mem[rd_ptr];
  assign count_nxt = count + CNT_W'(push_eff) - CNT_W'(pop_eff);

  always_ff @(posedge clk) begin
    if (push_eff) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_eff) wr_ptr <= step(wr_ptr);
      if (pop_eff)  rd_ptr <= step(rd_ptr);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/pdma_xfer_count.sv
`timescale 1ns/1ps
module pdma_xfer_count #(
  parameter int TC_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TC_W-1:0] load_val,
  input  logic            dec,
  input  logic            start,
  input  logic            done,
  output logic [TC_W-1:0] count,
  output logic            nonzero,
  output logic            zero_nxt,
  output logic            drq
);
  logic [TC_W-1:0] count_nxt;
  logic            armed_q;

  assign nonzero = (count != '0);

  always_comb begin
    count_nxt = count;
    if (load)              count_nxt = load_val;
    else if (dec && nonzero) count_nxt = count - 1'b1;
  end

  assign zero_nxt = (count_nxt == '0);
  assign drq      = armed_q && nonzero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      armed_q <= 1'b0;
    end else begin
      count <= count_nxt;
      if (done)                         armed_q <= 1'b0;
      else if (start)                   armed_q <= 1'b1;
      else if (dec && nonzero && zero_nxt) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pdma_host_seq.sv
`timescale 1ns/1ps
module pdma_host_seq
  import pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  output logic        acc_ready,
  input  logic        acc_write,
  input  logic [1:0]  acc_size,
  input  logic [15:0] acc_wdata,
  output logic        op_fire,
  output logic        op_write,
  output logic        op_last,
  output logic [7:0]  op_wbyte,
  input  logic [7:0]  op_rbyte,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  logic       phase_q, wr_q;
  logic [7:0] lo_q, hi_rd_q;
  logic       accept, take_byte, take_half;

  assign acc_ready = !phase_q;
  assign accept    = acc_valid && acc_ready;
  assign take_byte = accept && (acc_size == SZ_BYTE);
  assign take_half = accept && (acc_size == SZ_HALF);

  assign op_fire  = phase_q || take_byte || take_half;
  assign op_last  = phase_q || take_byte;
  assign op_write = phase_q ? wr_q : acc_write;

  always_comb begin
    if (phase_q)        op_wbyte = lo_q;
    else if (take_half) op_wbyte = acc_wdata[15:8];
    else                op_wbyte = acc_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      wr_q     <= 1'b0;
      lo_q     <= '0;
      hi_rd_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= op_fire && op_last && !op_write;
      if (op_fire && op_last && !op_write)
        rd_data <= phase_q ? {hi_rd_q, op_rbyte} : {8'h00, op_rbyte};
      if (take_half) begin
        phase_q <= 1'b1;
        wr_q    <= acc_write;
        lo_q    <= acc_wdata[7:0];
        hi_rd_q <= op_rbyte;
      end else if (phase_q) begin
        phase_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdma_port.sv
`timescale 1ns/1ps
module pdma_port #(
  parameter int TC_W       = 24,
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_mode,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic            acc_write,
  input  logic [1:0]      acc_size,
  input  logic [15:0]     acc_wdata,
  output logic            rd_valid,
  output logic [15:0]     rd_data,
  output logic            chk_evt,
  output logic            cmd_go,
  input  logic            tc_load,
  input  logic [TC_W-1:0] tc_load_val,
  input  logic            xfer_start,
  input  logic            xfer_done,
  output logic [TC_W-1:0] xfer_count,
  output logic            drq,
  input  logic            pad_req,
  input  logic            fill_valid,
  output logic            fill_ready,
  input  logic [7:0]      fill_data,
  output logic            drain_valid,
  input  logic            drain_ready,
  output logic [7:0]      drain_data,
  output logic            cmd_out_valid,
  input  logic            cmd_out_ready,
  output logic [7:0]      cmd_out_data
);
  localparam int DCNT_W = $clog2(DATA_DEPTH + 1);
  localparam int CCNT_W = $clog2(CMD_DEPTH + 1);

  logic             op_fire, op_write, op_last;
  logic [7:0]       op_wbyte, op_rbyte;
  logic             tc_nonzero, tc_zero_nxt;
  logic             wr_ok, host_rd, host_on_data, host_on_cmd;
  logic             d_push, d_pop, d_full, d_empty;
  logic [7:0]       d_push_data, d_head;
  logic [DCNT_W-1:0] d_cnt, d_cnt_nxt;
  logic             c_push, c_pop, c_full, c_empty;
  logic [7:0]       c_head;
  logic [CCNT_W-1:0] c_cnt, c_cnt_nxt;
  logic             pad_active_q, pad_push, fill_push, pad_ok;

  pdma_host_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_size(acc_size), .acc_wdata(acc_wdata),
    .op_fire(op_fire), .op_write(op_write), .op_last(op_last),
    .op_wbyte(op_wbyte), .op_rbyte(op_rbyte),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pdma_xfer_count #(.TC_W(TC_W)) u_tc (
    .clk(clk), .rst_n(rst_n),
    .load(tc_load), .load_val(tc_load_val),
    .dec(op_fire && op_write),
    .start(xfer_start), .done(xfer_done),
    .count(xfer_count), .nonzero(tc_nonzero), .zero_nxt(tc_zero_nxt),
    .drq(drq)
  );

  // Host byte routing
  assign wr_ok        = op_fire && op_write && tc_nonzero;
  assign host_rd      = op_fire && !op_write;
  assign host_on_data = op_fire && !cmd_mode;
  assign host_on_cmd  = op_fire && cmd_mode;
  assign op_rbyte     = cmd_mode ? c_head : d_head;

  // Zero padding of the data FIFO
  assign pad_ok   = (xfer_count <= TC_W'(DATA_DEPTH)) &&
                    (TC_W'(d_cnt) < xfer_count);
  assign pad_push = pad_active_q && !d_full && !host_on_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                          pad_active_q <= 1'b0;
    else if (!pad_active_q && pad_req)   pad_active_q <= pad_ok;
    else if (pad_active_q && d_full)     pad_active_q <= 1'b0;
  end

  // Target-side streams
  assign fill_ready    = !d_full && !pad_active_q && !host_on_data;
  assign fill_push     = fill_valid && fill_ready;
  assign drain_valid   = !d_empty && !host_on_data;
  assign drain_data    = d_head;
  assign cmd_out_valid = !c_empty && !host_on_cmd;
  assign cmd_out_data  = c_head;

  always_comb begin
    d_push      = 1'b0;
    d_push_data = 8'h00;
    if (wr_ok && !cmd_mode) begin
      d_push      = 1'b1;
      d_push_data = op_wbyte;
    end else if (fill_push) begin
      d_push      = 1'b1;
      d_push_data = fill_data;
    end else if (pad_push) begin
      d_push      = 1'b1;
    end
  end

  assign d_pop  = (host_rd && !cmd_mode) || (drain_valid && drain_ready);
  assign c_push = wr_ok && cmd_mode;
  assign c_pop  = (host_rd && cmd_mode) || (cmd_out_valid && cmd_out_ready);

  pdma_byte_fifo #(.DEPTH(DATA_DEPTH), .CNT_W(DCNT_W)) u_dfifo (
    .clk(clk), .rst_n(rst_n),
    .push(d_push), .push_data(d_push_data),
    .pop(d_pop), .pop_data(d_head),
    .count(d_cnt), .count_nxt(d_cnt_nxt),
    .full(d_full), .empty(d_empty)
  );

  pdma_byte_fifo #(.DEPTH(CMD_DEPTH), .CNT_W(CCNT_W)) u_cfifo (
    .clk(clk), .rst_n(rst_n),
    .push(c_push), .push_data(op_wbyte),
    .pop(c_pop), .pop_data(c_head),
    .count(c_cnt), .count_nxt(c_cnt_nxt),
    .full(c_full), .empty(c_empty)
  );

  // Completion-check and command hand-off events
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_evt <= 1'b0;
      cmd_go  <= 1'b0;
    end else begin
      chk_evt <= op_fire && op_last &&
                 (op_write || (d_cnt_nxt < DCNT_W'(2)));
      cmd_go  <= op_fire && op_last && op_write && cmd_mode &&
                 tc_zero_nxt && (c_cnt_nxt != '0);
    end
  end
endmodule

// File: rtl/pdma_port_checker.sv
`timescale 1ns/1ps
module pdma_port_checker #(
  parameter int TC_W       = 24,
  parameter int DATA_DEPTH = 16,
  parameter int DCNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [1:0]        acc_size,
  input logic              tc_load,
  input logic [TC_W-1:0]   xfer_count,
  input logic              drq,
  input logic              chk_evt,
  input logic              cmd_go,
  input logic              rd_valid,
  input logic              op_fire,
  input logic              op_write,
  input logic              fill_ready,
  input logic              d_full,
  input logic [DCNT_W-1:0] d_cnt
);
  a_r1_ready_after_half: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> $past(acc_valid && acc_ready && acc_size == 2'd1));

  a_r3_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tc_load) |-> xfer_count <= $past(xfer_count));

  a_r2_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(op_fire && !op_write));

  a_r6_event_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
    chk_evt |-> $past(op_fire));

  a_r8_go_needs_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (chk_evt && xfer_count == '0));

  a_r9_drq_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> xfer_count != '0);

  a_r5_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    d_cnt <= DCNT_W'(DATA_DEPTH));

  a_r11_fill_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> !d_full);
endmodule

bind pdma_port pdma_port_checker #(
  .TC_W(TC_W), .DATA_DEPTH(DATA_DEPTH), .DCNT_W(DCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_size(acc_size), .tc_load(tc_load), .xfer_count(xfer_count),
  .drq(drq), .chk_evt(chk_evt), .cmd_go(cmd_go), .rd_valid(rd_valid),
  .op_fire(op_fire), .op_write(op_write), .fill_ready(fill_ready),
  .d_full(d_full), .d_cnt(d_cnt)
);

// File: tb/pdma_port_bench.sv
`timescale 1ns/1ps
module pdma_port_bench;
  localparam int TC_W = 24;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_mode = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] acc_size = 2'd0;
  logic [15:0] acc_wdata = '0;
  logic tc_load = 1'b0, xfer_start = 1'b0, xfer_done = 1'b0, pad_req = 1'b0;
  logic [TC_W-1:0] tc_load_val = '0;
  logic fill_valid = 1'b0, drain_ready = 1'b0, cmd_out_ready = 1'b0;
  logic [7:0] fill_data = '0;
  logic acc_ready, rd_valid, chk_evt, cmd_go, drq;
  logic fill_ready, drain_valid, cmd_out_valid;
  logic [15:0] rd_data;
  logic [TC_W-1:0] xfer_count;
  logic [7:0] drain_data, cmd_out_data;

  int checks = 0, failures = 0;
  logic [7:0] dq[$], cq[$];
  int tc_m = 0;

  always #2.5 clk = ~clk;

  pdma_port #(.TC_W(TC_W), .DATA_DEPTH(DEPTH), .CMD_DEPTH(DEPTH)) u_pdma_port (
    .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .chk_evt(chk_evt), .cmd_go(cmd_go),
    .tc_load(tc_load), .tc_load_val(tc_load_val), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .xfer_count(xfer_count), .drq(drq),
    .pad_req(pad_req), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_data(fill_data), .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_data(drain_data), .cmd_out_valid(cmd_out_valid),
    .cmd_out_ready(cmd_out_ready), .cmd_out_data(cmd_out_data)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model of one host byte operation
  function automatic void m_wr(input logic cm, input logic [7:0] b);
    if (tc_m != 0) begin
      tc_m--;
      if (cm) begin if (cq.size() < DEPTH) cq.push_back(b); end
      else    begin if (dq.size() < DEPTH) dq.push_back(b); end
    end
  endfunction

  function automatic logic [7:0] m_rd(input logic cm);
    if (cm) return (cq.size() > 0) ? cq.pop_front() : 8'h00;
    return (dq.size() > 0) ? dq.pop_front() : 8'h00;
  endfunction

  task automatic do_acc(input logic wr, input logic [1:0] sz, input logic [15:0] wd,
                        output logic rv, output logic [15:0] rd,
                        output logic ce, output logic go);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_wdata = wd;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    if (sz == 2'd1) begin
      ck("R1 ready low on second byte", acc_ready, 0);
      @(posedge clk); @(negedge clk);
    end
    rv = rd_valid; rd = rd_data; ce = chk_evt; go = cmd_go;
  endtask

  // Access plus check against the model
  task automatic acc_chk(input logic cm, input logic wr, input logic [1:0] sz,
                         input logic [15:0] wd);
    logic rv, ce, go;
    logic [15:0] rd, exp_rd;
    logic exp_ce, exp_go;
    exp_rd = '0; exp_ce = 1'b0; exp_go = 1'b0;
    cmd_mode = cm;
    if (sz == 2'd0 || sz == 2'd1) begin
      if (wr) begin
        if (sz == 2'd1) begin m_wr(cm, wd[15:8]); m_wr(cm, wd[7:0]); end
        else m_wr(cm, wd[7:0]);
        exp_ce = 1'b1;
        exp_go = cm && (tc_m == 0) && (cq.size() != 0);
      end else begin
        if (sz == 2'd1) begin exp_rd[15:8] = m_rd(cm); exp_rd[7:0] = m_rd(cm); end
        else exp_rd[7:0] = m_rd(cm);
        exp_ce = (dq.size() < 2);
      end
    end
    do_acc(wr, sz, wd, rv, rd, ce, go);
    ck("R2 R10 rd_valid", rv, (!wr && (sz == 2'd0 || sz == 2'd1)));
    if (rv) ck("R2 R4 R5 read data", rd, exp_rd);
    ck("R6 R10 chk_evt", ce, exp_ce);
    ck("R8 cmd_go", go, exp_go);
    ck("R3 transfer count", xfer_count, tc_m);
  endtask

  task automatic load_tc(input int v);
    @(negedge clk); tc_load = 1'b1; tc_load_val = TC_W'(v);
    @(posedge clk); @(negedge clk); tc_load = 1'b0;
    tc_m = v;
  endtask

  task automatic drain_one(input logic [7:0] exp);
    @(negedge clk);
    ck("R11 drain_valid", drain_valid, 1);
    ck("R1 R5 R7 drain order", drain_data, exp);
    drain_ready = 1'b1;
    @(posedge clk); @(negedge clk); drain_ready = 1'b0;
    void'(dq.pop_front());
  endtask

  task automatic fill_one(input logic [7:0] b);
    @(negedge clk);
    ck("R11 fill_ready", fill_ready, 1);
    fill_valid = 1'b1; fill_data = b;
    @(posedge clk); @(negedge clk); fill_valid = 1'b0;
    dq.push_back(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic rv, ce, go;
    logic [15:0] rd;
    void'($urandom(32'h5EED1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    ck("reset xfer_count", xfer_count, 0);
    ck("R9 reset drq", drq, 0);
    ck("R6 reset chk_evt", chk_evt, 0);
    ck("R11 reset drain_valid", drain_valid, 0);
    ck("R1 reset acc_ready", acc_ready, 1);

    // R3: write with zero count is discarded
    acc_chk(1'b0, 1'b1, 2'd0, 16'h0077);
    acc_chk(1'b0, 1'b0, 2'd0, 16'h0);       // R5: empty pop returns zero

    // R1: halfword write order, R11 drain
    load_tc(5);
    acc_chk(1'b0, 1'b1, 2'd1, 16'hA1B2);
    drain_one(8'hA1); drain_one(8'hB2);
    @(negedge clk); ck("R11 drain empty", drain_valid, 0);

    // R9: drq follows start and count
    @(negedge clk); xfer_start = 1'b1; @(posedge clk); @(negedge clk); xfer_start = 1'b0;
    ck("R9 drq armed", drq, 1);
    acc_chk(1'b0, 1'b1, 2'd0, 16'h0011);
    acc_chk(1'b0, 1'b1, 2'd1, 16'h2233);
    ck("R9 drq drops at zero", drq, 0);
    load_tc(4);
    @(negedge clk); xfer_start = 1'b1; @(posedge clk); @(negedge clk); xfer_start = 1'b0;
    @(negedge clk); xfer_done = 1'b1; @(posedge clk); @(negedge clk); xfer_done = 1'b0;
    ck("R9 drq drops on done", drq, 0);

    // R2, R6: reads, event only below two bytes
    acc_chk(1'b0, 1'b1, 2'd1, 16'h1234);
    acc_chk(1'b0, 1'b0, 2'd1, 16'h0);
    acc_chk(1'b0, 1'b0, 2'd1, 16'h0);
    acc_chk(1'b0, 1'b0, 2'd0, 16'h0);

    // R4, R8: command collection and hand-off
    load_tc(3);
    acc_chk(1'b1, 1'b1, 2'd0, 16'h00C1);
    acc_chk(1'b1, 1'b1, 2'd1, 16'hC2C3);
    acc_chk(1'b1, 1'b0, 2'd1, 16'h0);
    cmd_mode = 1'b0;
    @(negedge clk);
    ck("R4 cmd_out_valid", cmd_out_valid, 1);
    ck("R4 cmd_out byte", cmd_out_data, cq[0]);
    cmd_out_ready = 1'b1; @(posedge clk); @(negedge clk); cmd_out_ready = 1'b0;
    void'(cq.pop_front());
    ck("R4 cmd fifo emptied", cmd_out_valid, 0);

    // R5: overflow drops, count still decrements
    load_tc(20);
    for (int i = 0; i < 17; i++) acc_chk(1'b0, 1'b1, 2'd0, 16'(8'h40 + i));
    for (int i = 0; i < 16; i++) drain_one(8'(8'h40 + i));
    @(negedge clk); ck("R5 overflow byte dropped", drain_valid, 0);

    // R10: wide accesses ignored
    acc_chk(1'b0, 1'b1, 2'd2, 16'hFFFF);
    acc_chk(1'b0, 1'b0, 2'd3, 16'h0);
    @(negedge clk); ck("R10 no data stored", drain_valid, 0);

    // R7: padding up to depth
    load_tc(10);
    fill_one(8'h91); fill_one(8'h92); fill_one(8'h93);
    @(negedge clk); pad_req = 1'b1; @(posedge clk); @(negedge clk); pad_req = 1'b0;
    repeat (20) @(negedge clk);
    ck("R7 fill blocked when full", fill_ready, 0);
    while (dq.size() < DEPTH) dq.push_back(8'h00);
    for (int i = 0; i < DEPTH; i++) drain_one(dq[0]);
    @(negedge clk); ck("R7 padded to depth", drain_valid, 0);
    load_tc(40);
    fill_one(8'h55); fill_one(8'h66);
    @(negedge clk); pad_req = 1'b1; @(posedge clk); @(negedge clk); pad_req = 1'b0;
    repeat (20) @(negedge clk);
    drain_one(8'h55); drain_one(8'h66);
    @(negedge clk); ck("R7 no pad above depth", drain_valid, 0);
    load_tc(0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom % 12;
      if (sel == 0) load_tc($urandom % 20);
      else acc_chk(1'($urandom % 2), sel < 6, (sel == 11) ? 2'd2 : 2'(sel % 2), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule